// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block sits between a host register port and an external byte-wide EEPROM. Through three registers (control, address, data) the host can read one byte from the EEPROM or write one byte to it. The EEPROM is reached over a simple request/acknowledge byte port, so the serial protocol and programming timing stay outside the block.

The block can also run a burst that copies EEPROM contents into on-chip memory without host help. The EEPROM holds a stream of three-byte records: a 16-bit little-endian offset and one data byte. Each record becomes one byte write to a 24-bit memory address. The upper 9 bits of that address come from a base register and the lower 15 bits come from the record's offset. A record whose offset is 0xFFFF ends the burst.

Only one operation runs at a time. The EEPROM address pointer is kept across operations, so a later burst can pick up where the last access stopped.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset, the control register (offset 0) and the burst register (offset 4) read 0, `ee_req`, `mem_we` and `burst_done` are low, and the address, data and base registers (offsets 1, 2, 3) read 0.
- R2: When idle, writing control bit 1 as 1 reads one byte from the EEPROM at the address register (offset 1, bits 15:0) into the data register (offset 2, bits 7:0). Control bit 1 then reads 1 until the transfer ends. The data register holds the new byte once bit 1 reads 0 again.
- R3: When idle, writing control bit 0 as 1 writes the data register's byte to the EEPROM at the address register's location, with `ee_we` high. Control bit 0 reads 1 until the transfer is done. If bits 0 and 1 are written as 1 together, only the read is done.
- R4: `ee_req` stays high, with `ee_addr`, `ee_we` and `ee_wdata` unchanged, until `ee_ack` is sampled high. Each clock cycle with both `ee_req` and `ee_ack` high completes exactly one byte transfer.
- R5: When idle, writing bit 0 of the burst register (offset 4) as 1 starts a burst. That bit and control bit 2 (busy) read 1 while the burst runs, and the hardware returns both to 0 when it ends.
- R6: A burst started after reset, with no earlier EEPROM access, fetches from address 0. Any other burst fetches from the address after the last byte transferred by any operation. Addresses advance modulo 2^16, so 0xFFFF is followed by 0x0000.
- R7: Each burst record is offset low byte, offset high byte, then data byte, in rising EEPROM address order. It produces one `mem_we` pulse with `mem_addr` = {base register bits 8:0, offset bits 14:0} and `mem_wdata` = the data byte. Offset bit 15 is ignored.
- R8: A record offset of 0xFFFF ends the burst. No memory write follows, its data byte is not fetched, the block goes idle, and `burst_done` is high for exactly one cycle.
- R9: While control bit 2 reads 1, every host register write is ignored: no operation starts and the address, data and base registers keep their values.
- R10: `mem_we` is never high in the same cycle as `ee_req`, and it lasts one cycle per record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Register offset for write and read |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the register at `host_addr` |
| ee_req | output | 1 | EEPROM byte transfer request |
| ee_we | output | 1 | Transfer is a write when high |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdata | input | 8 | EEPROM read byte, valid with `ee_ack` |
| ee_ack | input | 1 | Transfer complete |
| mem_we | output | 1 | Internal memory byte write strobe |
| mem_addr | output | 24 | Internal memory byte address |
| mem_wdata | output | 8 | Internal memory write byte |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The assertions check the cycle-level rules on every cycle:
- the request stays held with stable fields until it is acknowledged;
- a memory write never overlaps an EEPROM request, and each memory write follows a completed fetch;
- the pointer steps by one, modulo 2^16, after each transfer;
- the done pulse is a single cycle;
- the registers do not change under host writes while busy.

Only the bench scenarios show what the data does end to end:
- the byte a single read returns, and the byte and address a single write stores;
- a burst resuming at the right EEPROM address after a single access and after wrap-around;
- the composed memory addresses and data matching a record stream, including offsets with bit 15 set.

// File: rtl/eeb_pkg.sv
package eeb_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_BURST = 2'd3
  } eeb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_FETCH  = 2'd2,
    ST_STORE  = 2'd3
  } eeb_st_e;

  // register offsets on the host port
  localparam int unsigned REG_CTL   = 0;
  localparam int unsigned REG_ADDR  = 1;
  localparam int unsigned REG_DATA  = 2;
  localparam int unsigned REG_BASE  = 3;
  localparam int unsigned REG_BURST = 4;

  // control register bit positions
  localparam int unsigned CTL_WR_BIT   = 0;
  localparam int unsigned CTL_RD_BIT   = 1;
  localparam int unsigned CTL_BUSY_BIT = 2;

  // burst record fetch phases
  localparam logic [1:0] PH_LO   = 2'd0;
  localparam logic [1:0] PH_HI   = 2'd1;
  localparam logic [1:0] PH_DATA = 2'd2;

endpackage

// File: rtl/eeb_regfile.sv
module eeb_regfile
  import eeb_pkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int HOST_DW = 32,
  parameter int EE_AW   = 16,
  parameter int EE_DW   = 8,
  parameter int BASE_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               busy,
  input  eeb_op_e            cur_op,
  input  logic               rd_load,
  input  logic [EE_DW-1:0]   rd_byte,
  output logic [EE_AW-1:0]   addr_q,
  output logic [EE_DW-1:0]   data_q,
  output logic [BASE_W-1:0]  base_q,
  output eeb_op_e            req_op
);

  logic accept;
  logic sel_ctl, sel_addr, sel_data, sel_base, sel_burst;
  logic unused_wdata_hi;

  assign accept    = host_we && !busy;
  assign sel_ctl   = (host_addr == HOST_AW'(REG_CTL));
  assign sel_addr  = (host_addr == HOST_AW'(REG_ADDR));
  assign sel_data  = (host_addr == HOST_AW'(REG_DATA));
  assign sel_base  = (host_addr == HOST_AW'(REG_BASE));
  assign sel_burst = (host_addr == HOST_AW'(REG_BURST));
  assign unused_wdata_hi = ^host_wdata[HOST_DW-1:EE_AW];

  // a read request outranks a write request in the same control write
  function automatic eeb_op_e ctl_decode(input logic rd_bit, input logic wr_bit);
    if (rd_bit)      return OP_READ;
    else if (wr_bit) return OP_WRITE;
    else             return OP_NONE;
  endfunction

  always_comb begin
    req_op = OP_NONE;
    if (accept) begin
      if (sel_ctl)
        req_op = ctl_decode(host_wdata[CTL_RD_BIT], host_wdata[CTL_WR_BIT]);
      else if (sel_burst && host_wdata[0])
        req_op = OP_BURST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      if (accept && sel_addr) addr_q <= host_wdata[EE_AW-1:0];
      if (accept && sel_base) base_q <= host_wdata[BASE_W-1:0];
      if (rd_load)                  data_q <= rd_byte;
      else if (accept && sel_data)  data_q <= host_wdata[EE_DW-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (sel_ctl) begin
      host_rdata[CTL_WR_BIT]   = busy && (cur_op == OP_WRITE);
      host_rdata[CTL_RD_BIT]   = busy && (cur_op == OP_READ);
      host_rdata[CTL_BUSY_BIT] = busy;
    end else if (sel_addr)  host_rdata = HOST_DW'(addr_q);
    else if (sel_data)      host_rdata = HOST_DW'(data_q);
    else if (sel_base)      host_rdata = HOST_DW'(base_q);
    else if (sel_burst)     host_rdata[0] = busy && (cur_op == OP_BURST);
  end

endmodule

// File: rtl/eeb_ptr.sv
module eeb_ptr #(
  parameter int EE_AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [EE_AW-1:0] cur_addr,
  output logic [EE_AW-1:0] ptr_q
);

  // next byte after a completed transfer, modulo the address range
  function automatic logic [EE_AW-1:0] after(input logic [EE_AW-1:0] a);
    return a + EE_AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= after(cur_addr);
  end

endmodule

// File: rtl/eeb_seq.sv
module eeb_seq
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int EE_DW  = 8,
  parameter int MEM_AW = 24,
  parameter int OFS_W  = 15,
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eeb_op_e           req_op,
  input  logic [EE_AW-1:0]  addr_q,
  input  logic [EE_DW-1:0]  data_q,
  input  logic [BASE_W-1:0] base_q,
  input  logic [EE_AW-1:0]  ptr_q,
  input  logic              ee_ack,
  input  logic [EE_DW-1:0]  ee_rdata,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [EE_DW-1:0]  ee_wdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [EE_DW-1:0]  mem_wdata,
  output logic              busy,
  output eeb_op_e           op_q,
  output logic              rd_load,
  output logic              xfer,
  output logic              burst_done
);

  localparam int REC_AW = 2 * EE_DW;

  eeb_st_e           st_q;
  logic [1:0]        phase_q;
  logic [EE_DW-1:0]  lo_q;
  logic [OFS_W-1:0]  off_q;
  logic [EE_DW-1:0]  dbyte_q;
  logic              done_q;
  logic [REC_AW-1:0] rec_raw;

  function automatic logic is_end(input logic [REC_AW-1:0] raw);
    return &raw;
  endfunction

  function automatic logic [MEM_AW-1:0] compose(input logic [BASE_W-1:0] b,
                                                input logic [OFS_W-1:0] o);
    return {b, o};
  endfunction

  assign rec_raw = {ee_rdata, lo_q};

  always_comb begin
    ee_req  = 1'b0;
    ee_we   = 1'b0;
    ee_addr = ptr_q;
    mem_we  = 1'b0;
    unique case (st_q)
      ST_SINGLE: begin
        ee_req  = 1'b1;
        ee_addr = addr_q;
        ee_we   = (op_q == OP_WRITE);
      end
      ST_FETCH: ee_req = 1'b1;
      ST_STORE: mem_we = 1'b1;
      default: ;
    endcase
  end

  assign ee_wdata   = data_q;
  assign xfer       = ee_req && ee_ack;
  assign busy       = (st_q != ST_IDLE);
  assign rd_load    = (st_q == ST_SINGLE) && ee_ack && (op_q == OP_READ);
  assign mem_addr   = compose(base_q, off_q);
  assign mem_wdata  = dbyte_q;
  assign burst_done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      phase_q <= PH_LO;
      lo_q    <= '0;
      off_q   <= '0;
      dbyte_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_op != OP_NONE) begin
            op_q    <= req_op;
            phase_q <= PH_LO;
            st_q    <= (req_op == OP_BURST) ? ST_FETCH : ST_SINGLE;
          end
        end
        ST_SINGLE: begin
          if (ee_ack) begin
            st_q <= ST_IDLE;
            op_q <= OP_NONE;
          end
        end
        ST_FETCH: begin
          if (ee_ack) begin
            unique case (phase_q)
              PH_LO: begin
                lo_q    <= ee_rdata;
                phase_q <= PH_HI;
              end
              PH_HI: begin
                if (is_end(rec_raw)) begin
                  st_q   <= ST_IDLE;
                  op_q   <= OP_NONE;
                  done_q <= 1'b1;
                end else begin
                  off_q   <= rec_raw[OFS_W-1:0];
                  phase_q <= PH_DATA;
                end
              end
              default: begin
                dbyte_q <= ee_rdata;
                phase_q <= PH_LO;
                st_q    <= ST_STORE;
              end
            endcase
          end
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
  import eeb_pkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int HOST_DW = 32,
  parameter int EE_AW   = 16,
  parameter int EE_DW   = 8,
  parameter int MEM_AW  = 24,
  parameter int OFS_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               ee_req,
  output logic               ee_we,
  output logic [EE_AW-1:0]   ee_addr,
  output logic [EE_DW-1:0]   ee_wdata,
  input  logic [EE_DW-1:0]   ee_rdata,
  input  logic               ee_ack,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [EE_DW-1:0]   mem_wdata,
  output logic               burst_done
);

  localparam int BASE_W = MEM_AW - OFS_W;

  logic [EE_AW-1:0]  addr_q;
  logic [EE_DW-1:0]  data_q;
  logic [BASE_W-1:0] base_q;
  logic [EE_AW-1:0]  ptr_q;
  eeb_op_e           req_op;
  eeb_op_e           op_q;
  logic              busy;
  logic              rd_load;
  logic              xfer;

  eeb_regfile #(
    .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .EE_AW(EE_AW),
    .EE_DW(EE_DW), .BASE_W(BASE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .cur_op(op_q),
    .rd_load(rd_load), .rd_byte(ee_rdata),
    .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
    .req_op(req_op)
  );

  eeb_ptr #(.EE_AW(EE_AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .step(xfer), .cur_addr(ee_addr),
    .ptr_q(ptr_q)
  );

  eeb_seq #(
    .EE_AW(EE_AW), .EE_DW(EE_DW), .MEM_AW(MEM_AW),
    .OFS_W(OFS_W), .BASE_W(BASE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_op(req_op), .addr_q(addr_q), .data_q(data_q),
    .base_q(base_q), .ptr_q(ptr_q),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .op_q(op_q), .rd_load(rd_load), .xfer(xfer),
    .burst_done(burst_done)
  );

endmodule

// File: rtl/eeb_checker.sv
module eeb_checker #(
  parameter int EE_AW  = 16,
  parameter int EE_DW  = 8,
  parameter int BASE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic              ee_req,
  input logic              ee_ack,
  input logic              ee_we,
  input logic [EE_AW-1:0]  ee_addr,
  input logic [EE_DW-1:0]  ee_wdata,
  input logic              mem_we,
  input logic              burst_done,
  input logic              busy,
  input logic              xfer,
  input logic [EE_AW-1:0]  ptr_q,
  input logic [EE_AW-1:0]  addr_q,
  input logic [BASE_W-1:0] base_q
);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (ptr_q == EE_AW'($past(ee_addr) + EE_AW'(1))));

  assert_store_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(xfer));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!busy && !mem_we && !ee_req));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && busy) |=> ($stable(addr_q) && $stable(base_q)));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_req && mem_we));

  assert_store_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind eeprom_burst_loader eeb_checker #(
  .EE_AW(EE_AW), .EE_DW(EE_DW), .BASE_W(BASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we),
  .ee_req(ee_req), .ee_ack(ee_ack), .ee_we(ee_we),
  .ee_addr(ee_addr), .ee_wdata(ee_wdata),
  .mem_we(mem_we), .burst_done(burst_done),
  .busy(busy), .xfer(xfer), .ptr_q(ptr_q),
  .addr_q(addr_q), .base_q(base_q)
);

// File: tb/eeprom_burst_loader_test.sv
`timescale 1ns/1ps
module eeprom_burst_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ee_req, ee_we;
  logic [15:0] ee_addr;
  logic [7:0]  ee_wdata;
  logic [7:0]  ee_rdata = '0;
  logic        ee_ack = 1'b0;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        burst_done;

  always #4 clk = ~clk;

  eeprom_burst_loader uut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_rdata(ee_rdata), .ee_ack(ee_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .burst_done(burst_done)
  );

  int checks = 0;
  int fails  = 0;

  // EEPROM model state (256 bytes, aliased over the 16-bit space)
  logic [7:0]  rom [0:255];
  int          lat = 0;
  int          xfer_cnt = 0;
  int          wr_cnt = 0;
  logic [15:0] last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;
  logic [15:0] first_addr = '0;
  int          mark = 0;
  int          hs_err = 0;
  logic        prev_req = 1'b0, prev_ack = 1'b0;
  logic [15:0] prev_addr = '0;

  // memory side log
  logic [23:0] mlog_a [0:63];
  logic [7:0]  mlog_d [0:63];
  int          mcnt = 0;
  int          done_cnt = 0;

  // expected burst
  logic [23:0] exp_a [0:63];
  logic [7:0]  exp_d [0:63];
  int          exp_n, exp_x;

  always @(negedge clk) begin
    // R4: a raised request may not drop or move before its acknowledge
    if (rst_n && prev_req && !prev_ack && (!ee_req || ee_addr != prev_addr)) hs_err++;
    if (!rst_n) begin
      ee_ack = 1'b0;
    end else if (ee_ack) begin
      ee_ack = 1'b0;
      lat = $urandom % 3;
    end else if (ee_req) begin
      if (lat == 0) begin
        ee_ack = 1'b1;
        ee_rdata = rom[ee_addr[7:0]];
        if (ee_we) begin
          rom[ee_addr[7:0]] = ee_wdata;
          wr_cnt++;
          last_wr_addr = ee_addr;
          last_wr_data = ee_wdata;
        end
        if (xfer_cnt == mark) first_addr = ee_addr;
        xfer_cnt++;
      end else lat--;
    end
    prev_req = ee_req;
    prev_ack = ee_ack;
    prev_addr = ee_addr;
    if (rst_n && mem_we) begin
      if (mcnt < 64) begin
        mlog_a[mcnt] = mem_addr;
        mlog_d[mcnt] = mem_wdata;
      end
      mcnt++;
    end
    if (rst_n && burst_done) done_cnt++;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    #1;
    host_addr = a[2:0];
    host_wdata = d;
    host_we = 1'b1;
    @(negedge clk);
    #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    host_addr = a[2:0];
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      #2;
      rd(0, v);
      if (v[2] == 1'b0) break;
    end
  endtask

  function automatic logic [23:0] mem_target(input logic [8:0] b, input logic [15:0] raw);
    return (24'(b) << 15) | 24'(raw & 16'h7FFF);
  endfunction

  // walk the record stream the way R7/R8 describe it
  task automatic plan_burst(input logic [15:0] start, input logic [8:0] b);
    logic [15:0] p, raw;
    p = start;
    exp_n = 0;
    exp_x = 0;
    for (int i = 0; i < 60; i++) begin
      raw = {rom[8'(p + 16'd1)], rom[p[7:0]]};
      p = p + 16'd2;
      exp_x += 2;
      if (raw == 16'hFFFF) break;
      exp_a[exp_n] = mem_target(b, raw);
      exp_d[exp_n] = rom[p[7:0]];
      p = p + 16'd1;
      exp_x += 1;
      exp_n++;
    end
  endtask

  task automatic put_prog(input int at, input int nrec);
    int p;
    logic [15:0] raw;
    p = at;
    for (int i = 0; i < nrec; i++) begin
      raw = 16'($urandom);
      if (i == 0) raw = raw | 16'h8000;
      if (raw == 16'hFFFF) raw = 16'h1234;
      rom[8'(p)] = raw[7:0];
      rom[8'(p + 1)] = raw[15:8];
      rom[8'(p + 2)] = 8'($urandom);
      p += 3;
    end
    rom[8'(p)] = 8'hFF;
    rom[8'(p + 1)] = 8'hFF;
  endtask

  task automatic run_burst(input string tag, input logic [15:0] start,
                           input logic [8:0] b, input bit poke);
    logic [31:0] v, a0, d0;
    wr(3, 32'(b));
    plan_burst(start, b);
    rd(1, a0);
    rd(2, d0);
    mcnt = 0;
    done_cnt = 0;
    mark = xfer_cnt;
    wr(4, 32'h1);
    rd(4, v);
    check("R5", {tag, " burst bit set while running"}, v[0], 1'b1);
    rd(0, v);
    check("R5", {tag, " busy while running"}, v[2], 1'b1);
    if (poke) begin
      wr(1, 32'h0000_ABCD);
      wr(0, 32'h2);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    #2;
    rd(4, v);
    check("R5", {tag, " burst bit cleared"}, v[0], 1'b0);
    check("R6", {tag, " first fetch address"}, first_addr, start);
    check("R7", {tag, " memory write count"}, mcnt, exp_n);
    for (int i = 0; i < exp_n && i < 64; i++) begin
      check("R7", {tag, " memory address"}, mlog_a[i], exp_a[i]);
      check("R7", {tag, " memory data"}, mlog_d[i], exp_d[i]);
    end
    check("R8", {tag, " done pulses"}, done_cnt, 1);
    check("R8", {tag, " EEPROM transfers"}, xfer_cnt - mark, exp_x);
    if (poke) begin
      rd(1, v);
      check("R9", {tag, " address unchanged"}, v, a0);
      rd(2, v);
      check("R9", {tag, " data unchanged"}, v, d0);
    end
  endtask

  task automatic single_read(input logic [15:0] a);
    logic [31:0] v;
    int x0;
    wr(1, 32'(a));
    x0 = wr_cnt;
    wr(0, 32'h2);
    rd(0, v);
    check("R2", "read pending bit", v[1:0], 2'b10);
    wait_idle();
    rd(0, v);
    check("R2", "read bit cleared", v[1], 1'b0);
    rd(2, v);
    check("R2", "read byte", v, 32'(rom[a[7:0]]));
    check("R2", "no EEPROM write", wr_cnt, x0);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] a;
    logic [7:0]  d;
    int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) rom[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(0, v); check("R1", "control after reset", v, 0);
    rd(4, v); check("R1", "burst reg after reset", v, 0);
    rd(1, v); check("R1", "address after reset", v, 0);
    rd(2, v); check("R1", "data after reset", v, 0);
    rd(3, v); check("R1", "base after reset", v, 0);
    check("R1", "outputs idle", {ee_req, mem_we, burst_done}, 3'b000);
    rst_n = 1'b1;

    // R5 R6 R7 R8 R9: first burst from address 0 with ignored host writes
    put_prog(0, 3);
    run_burst("burst0", 16'h0000, 9'($urandom), 1'b1);
    // R6: next burst resumes after the terminator
    put_prog(11, 2);
    run_burst("burst1", 16'd11, 9'($urandom), 1'b0);

    // R2: random single reads
    for (int i = 0; i < 6; i++) single_read(16'($urandom));

    // R3: random single writes
    for (int i = 0; i < 5; i++) begin
      a = 16'($urandom) | 16'h0080;
      d = 8'($urandom);
      w0 = wr_cnt;
      wr(1, 32'(a));
      wr(2, 32'(d));
      wr(0, 32'h1);
      rd(0, v);
      check("R3", "write pending bit", v[1:0], 2'b01);
      wait_idle();
      check("R3", "one EEPROM write", wr_cnt - w0, 1);
      check("R3", "write address", last_wr_addr, a);
      check("R3", "write byte", last_wr_data, d);
    end

    // R3: both bits set, read wins
    w0 = wr_cnt;
    wr(1, 32'h0000_1042);
    wr(2, 32'h0000_005A);
    wr(0, 32'h3);
    wait_idle();
    check("R3", "both bits: no write", wr_cnt - w0, 0);
    rd(2, v);
    check("R3", "both bits: read byte", v, 32'(rom[8'h42]));

    // R6: burst resumes after a single access
    put_prog(8'h21, 1);
    single_read(16'h3320);
    run_burst("resume", 16'h3321, 9'h1AB, 1'b0);

    // R6 R8: wrap from 0xFFFF to 0x0000, immediate terminator
    rom[0] = 8'hFF;
    rom[1] = 8'hFF;
    single_read(16'hFFFF);
    run_burst("wrap", 16'h0000, 9'h0F0, 1'b0);

    // R4: handshake discipline seen from the EEPROM side
    check("R4", "request held until acknowledge", hs_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule